// File: doc/BRIEF.md
# Chainable SPI Slave Shifter

This block is an SPI slave for a host bus. It is made of identical byte-wide slices. Each slice holds a transmit register, a receive buffer, a control register and a shift register. On its own, slice 0 works as an 8-bit slave. When the chain bit of slice 0 is set, all slices join into one wide slave. With the default two slices this gives a 16-bit word, and slice 1 holds the most significant byte. The serial clock, select and data-in pins pass through a two-flop synchroniser. Edges of the serial clock are then detected in the system clock domain, so the serial clock must run several times slower than the system clock.

The main subtlety is deciding when a new transmit word may enter the shifter. A word written while no transfer is in progress is loaded at once. A word written during a transfer is held and loaded at the next word boundary. In the two modes that sample on the leading edge, a transfer starts when select falls. In the two modes that shift out on the leading edge, a transfer starts at the first leading clock edge, and select plays no part. Software writes the upper transmit byte before the lower one, and reads the upper receive byte before the lower one. When it follows that order, the status of slice 0 describes the whole word.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, every slice reports status 0x02 (transmit empty only), all interrupts are low and MISO is low.
- R2: Status bits: bit0 word complete, bit1 transmit empty, bit2 overrun, bit3 transfer in progress. Register addresses: 0 transmit, 1 receive, 2 control, 3 status. With slice 0 enabled and unchained, an 8-bit exchange sends the loaded transmit byte MSB first on MISO, stores the MOSI byte in the receive buffer and sets word complete.
- R3: Control bits: bit0 enable, bit1 clock idle level, bit2 clock phase, bit3 chain, bit4 interrupt enable, bit5 interrupt source (1 = transmit empty, 0 = word complete). Mode m sets phase = m[1] and idle level = m[0]. Phase 0 samples on the leading edge, and phase 1 launches on the leading edge and samples on the trailing edge. All four modes exchange data correctly.
- R4: With chain set, a transfer takes 16 bits. MISO sends {slice 1 transmit, slice 0 transmit} MSB first, and the received word is split with the upper byte in slice 1.
- R5: Only slice 0's enable bit gates the block. With slice 0 disabled, clock activity changes no status and no receive data. Slice 1's enable bit has no effect on a chained transfer.
- R6: When chained, writing only the slice 1 transmit register leaves that slice's transmit-empty bit at 0. The word loads, and both empty bits return to 1, only after the slice 0 transmit write.
- R7: A transmit write during a transfer in progress is held, with transmit empty kept at 0, until the word completes. The byte then loads for the next word. In phase-0 modes a transfer is in progress from the falling edge of select. In phase-1 modes a falling select alone does not start one.
- R8: With select held low, consecutive words are exchanged correctly in both phase settings.
- R9: Reading a slice's status clears its word-complete and overrun bits. Writing a slice's transmit register clears its transmit-empty bit.
- R10: A word completing before the previous one was read (slice 0 receive read) sets overrun. The receive buffer still takes the new word.
- R11: A slice's interrupt is high exactly when its interrupt enable is set and its selected source bit is set.
- R12: A rise of select in the middle of a word discards the partial word, without setting word complete, and the next word starts counting afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, low when not selected |
| bus_sel | input | SEL_W | Slice index for register access |
| bus_addr | input | 2 | Register address within the slice |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | SLICE_W | Write data |
| bus_rdata | output | SLICE_W | Read data, valid the cycle after the read strobe |
| irq | output | N_SLICES | Interrupt per slice |

## Verification
A wrong bit counter or a wrong phase choice shows up within one word at MISO, as a shifted or rotated byte, and at the next receive read as a corrupted word. A wrong in-progress flag shows up at once in the status byte read right after a transmit write. It appears as transmit empty returning too early or too late, and on the following word as the wrong byte on MISO. Chain wiring errors appear as swapped or duplicated bytes in the 16-bit exchange. Stale status flags appear at the next status read or at the interrupt pin one cycle later.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  typedef enum logic [1:0] {
    REG_TX   = 2'd0,
    REG_RX   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // bit0 en, bit1 cpol, bit2 cpha, bit3 chain, bit4 ien, bit5 isel
  typedef struct packed {
    logic isel;
    logic ien;
    logic chain;
    logic cpha;
    logic cpol;
    logic en;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int ST_DONE = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_BUSY = 3;

endpackage

// File: rtl/spi_edge_front.sv
module spi_edge_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ss_fall,
  output logic ss_rise,
  output logic ss_low,
  output logic mosi_s
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sh, ss_sh, mosi_sh;
  logic sclk_d, ss_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh <= '0;
      ss_sh   <= '1;
      mosi_sh <= '0;
      sclk_d  <= 1'b0;
      ss_d    <= 1'b1;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-2:0], sclk};
      ss_sh   <= {ss_sh[SYNC_STAGES-2:0], ss_n};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_sh[LAST];
      ss_d    <= ss_sh[LAST];
    end
  end

  assign sclk_rise = sclk_sh[LAST] & ~sclk_d;
  assign sclk_fall = ~sclk_sh[LAST] & sclk_d;
  assign ss_fall   = ~ss_sh[LAST] & ss_d;
  assign ss_rise   = ss_sh[LAST] & ~ss_d;
  assign ss_low    = ~ss_sh[LAST];
  assign mosi_s    = mosi_sh[LAST];

endmodule

// File: rtl/spi_chain_seq.sv
module spi_chain_seq #(
  parameter int SLICE_W  = 8,
  parameter int WORD_MAX = 16,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          chain,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          ss_fall,
  input  logic          ss_rise,
  input  logic          ss_low,
  input  logic          mosi_s,
  input  logic          tx_wr0,
  output logic          load,
  output logic          shift,
  output logic          complete,
  output logic          ser_in,
  output logic          busy,
  output logic          pending,
  output logic [CW-1:0] cnt
);
  logic lead, trail, act, cap, lau, last, sample;
  logic [CW-1:0] word_len;

  always_comb begin
    lead     = cpol ? sclk_fall : sclk_rise;
    trail    = cpol ? sclk_rise : sclk_fall;
    act      = en & ss_low;
    cap      = act & (cpha ? trail : lead);
    lau      = act & (cpha ? lead : trail);
    word_len = chain ? CW'(WORD_MAX) : CW'(SLICE_W);
    last     = (cnt == word_len - CW'(1));
    complete = cap & last;
    shift    = (lau & (cnt != '0)) | complete;
    ser_in   = complete ? mosi_s : sample;
    load     = en & pending & ~busy;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      busy   <= 1'b0;
      sample <= 1'b0;
    end else if (ss_rise) begin
      cnt    <= '0;
      busy   <= 1'b0;
    end else if (cap) begin
      sample <= mosi_s;
      if (last) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt  <= cnt + CW'(1);
        busy <= 1'b1;
      end
    end else if (lau && cnt == '0 && cpha) begin
      busy <= 1'b1;
    end else if (ss_fall && !cpha) begin
      busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (tx_wr0) pending <= 1'b1;
    else if (load)   pending <= 1'b0;
  end

endmodule

// File: rtl/spi_slice.sv
module spi_slice
  import spi_chain_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_tx,
  input  logic         wr_ctrl,
  input  logic         rd_stat,
  input  logic         rx_ack,
  input  reg_sel_e     addr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  input  logic         shift,
  input  logic         complete,
  input  logic         ser_in,
  input  logic         busy,
  output ctrl_t        ctrl,
  output logic         ser_out,
  output logic         done,
  output logic         txe,
  output logic         ovr,
  output logic         unread,
  output logic         irq,
  output logic [W-1:0] rdata
);
  logic [W-1:0] tx_q, rx_q, sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      sh_q   <= '0;
      ctrl   <= '0;
      done   <= 1'b0;
      txe    <= 1'b1;
      ovr    <= 1'b0;
      unread <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_tx)   tx_q <= wdata;
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (load)       sh_q <= tx_q;
      else if (shift) sh_q <= {sh_q[W-2:0], ser_in};
      if (complete)   rx_q <= {sh_q[W-2:0], ser_in};
      if (complete)     done <= 1'b1;
      else if (rd_stat) done <= 1'b0;
      if (complete && unread) ovr <= 1'b1;
      else if (rd_stat)       ovr <= 1'b0;
      if (complete)    unread <= 1'b1;
      else if (rx_ack) unread <= 1'b0;
      if (wr_tx)     txe <= 1'b0;
      else if (load) txe <= 1'b1;
      irq <= ctrl.ien & (ctrl.isel ? txe : done);
    end
  end

  assign ser_out = sh_q[W-1];

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_TX:   rdata = tx_q;
      REG_RX:   rdata = rx_q;
      REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
      REG_STAT: begin
        rdata[ST_DONE] = done;
        rdata[ST_TXE]  = txe;
        rdata[ST_OVR]  = ovr;
        rdata[ST_BUSY] = busy;
      end
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int SLICE_W     = 8,
  parameter int N_SLICES    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                ss_n,
  input  logic                mosi,
  output logic                miso,
  input  logic [SEL_W-1:0]    bus_sel,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [SLICE_W-1:0]  bus_wdata,
  output logic [SLICE_W-1:0]  bus_rdata,
  output logic [N_SLICES-1:0] irq
);
  localparam int WORD_MAX = SLICE_W * N_SLICES;
  localparam int CW       = $clog2(WORD_MAX + 1);

  logic sclk_rise, sclk_fall, ss_fall, ss_rise, ss_low, mosi_s;
  logic seq_load, seq_shift, seq_complete, seq_ser_in, seq_busy, seq_pending;
  logic [CW-1:0] seq_cnt;

  ctrl_t ctrl_v [N_SLICES];
  logic [SLICE_W-1:0] rd_v [N_SLICES];
  logic [N_SLICES-1:0] done_v, txe_v, ovr_v, unread_v, ser_out_v, ser_in_v;
  logic [N_SLICES-1:0] hit, wr_tx_v, ack_own, ack_v;
  logic chain_on, top_bit;
  reg_sel_e addr_e;

  assign chain_on = ctrl_v[0].chain;
  assign addr_e   = reg_sel_e'(bus_addr);
  assign top_bit  = chain_on ? ser_out_v[N_SLICES-1] : ser_out_v[0];

  spi_edge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_fall(ss_fall),
    .ss_rise(ss_rise), .ss_low(ss_low), .mosi_s(mosi_s)
  );

  spi_chain_seq #(.SLICE_W(SLICE_W), .WORD_MAX(WORD_MAX), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .en(ctrl_v[0].en), .cpol(ctrl_v[0].cpol),
    .cpha(ctrl_v[0].cpha), .chain(chain_on), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .ss_fall(ss_fall), .ss_rise(ss_rise),
    .ss_low(ss_low), .mosi_s(mosi_s), .tx_wr0(wr_tx_v[0]),
    .load(seq_load), .shift(seq_shift), .complete(seq_complete),
    .ser_in(seq_ser_in), .busy(seq_busy), .pending(seq_pending), .cnt(seq_cnt)
  );

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    logic act;
    assign act        = (i == 0) || chain_on;
    assign hit[i]     = (bus_sel == SEL_W'(i));
    assign wr_tx_v[i] = bus_wr & hit[i] & (addr_e == REG_TX);
    assign ack_own[i] = bus_rd & hit[i] & (addr_e == REG_RX);

    if (i == 0) begin : g_lsb
      assign ser_in_v[i] = seq_ser_in;
      assign ack_v[i]    = ack_own[0];
    end else begin : g_upper
      assign ser_in_v[i] = ser_out_v[i-1];
      assign ack_v[i]    = chain_on ? ack_own[0] : ack_own[i];
    end

    spi_slice #(.W(SLICE_W)) u_slice (
      .clk(clk), .rst(rst), .wr_tx(wr_tx_v[i]),
      .wr_ctrl(bus_wr & hit[i] & (addr_e == REG_CTRL)),
      .rd_stat(bus_rd & hit[i] & (addr_e == REG_STAT)),
      .rx_ack(ack_v[i]), .addr(addr_e), .wdata(bus_wdata),
      .load(seq_load & act), .shift(seq_shift & act),
      .complete(seq_complete & act), .ser_in(ser_in_v[i]),
      .busy(seq_busy & act), .ctrl(ctrl_v[i]), .ser_out(ser_out_v[i]),
      .done(done_v[i]), .txe(txe_v[i]), .ovr(ovr_v[i]),
      .unread(unread_v[i]), .irq(irq[i]), .rdata(rd_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      miso <= ss_low & ctrl_v[0].en & top_bit;
      if (bus_rd) bus_rdata <= rd_v[bus_sel];
    end
  end

endmodule

// File: rtl/spi_chain_chk.sv
module spi_chain_chk #(
  parameter int CW       = 5,
  parameter int WORD_MAX = 16,
  parameter int SEL_W    = 1,
  parameter int N_SLICES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [SEL_W-1:0]    bus_sel,
  input logic [1:0]          bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [N_SLICES-1:0] irq,
  input logic                busy,
  input logic                pending,
  input logic                complete,
  input logic                ss_rise,
  input logic [CW-1:0]       cnt,
  input logic                done0,
  input logic                txe0,
  input logic                ovr0,
  input logic                unread0,
  input logic                ien0,
  input logic                en0
);
  // R1
  a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq == '0);
  // R4
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(WORD_MAX));
  // R7
  a_r7_tx_held_in_progress: assert property (@(posedge clk) disable iff (rst)
    busy && pending |=> !txe0);
  // R9
  a_r9_done_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_sel == '0 && bus_addr == 2'd3 && !complete |=> !done0);
  // R9
  a_r9_txe_clear_on_write: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_sel == '0 && bus_addr == 2'd0 |=> !txe0);
  // R10
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (rst)
    complete && unread0 |=> ovr0);
  // R11
  a_r11_irq_off_when_masked: assert property (@(posedge clk) disable iff (rst)
    !ien0 |=> !irq[0]);
  // R12
  a_r12_abort_on_ss_rise: assert property (@(posedge clk) disable iff (rst)
    ss_rise && en0 |=> cnt == '0 && !busy);
endmodule

bind spi_chain_slave spi_chain_chk #(
  .CW(CW), .WORD_MAX(SLICE_W * N_SLICES), .SEL_W(SEL_W), .N_SLICES(N_SLICES)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .irq(irq), .busy(seq_busy),
  .pending(seq_pending), .complete(seq_complete), .ss_rise(ss_rise),
  .cnt(seq_cnt), .done0(done_v[0]), .txe0(txe_v[0]), .ovr0(ovr_v[0]),
  .unread0(unread_v[0]), .ien0(ctrl_v[0].ien), .en0(ctrl_v[0].en)
);

// File: tb/sim_spi_chain_slave.sv
`timescale 1ns/1ps
module sim_spi_chain_slave;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [0:0] bus_sel = '0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [N-1:0] irq;

  int checks = 0, errors = 0;
  logic cpol = 1'b0, cpha = 1'b0;

  always #2.5 clk = ~clk;

  spi_chain_slave u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] stat(input logic done, txe, ovr, busy);
    return {4'b0, busy, ovr, txe, done};
  endfunction

  function automatic logic [7:0] ctrl(input logic [1:0] mode, input logic chain,
                                      input logic ien, input logic isel, input logic en);
    return {2'b0, isel, ien, chain, mode[1], mode[0], en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mode(input logic [1:0] m, input logic chain, input logic ien,
                          input logic isel, input logic en);
    cpol = m[0]; cpha = m[1];
    sclk = cpol;
    wait_clk(4);
    wr(1'b0, 2'd2, ctrl(m, chain, ien, isel, en));
  endtask

  task automatic ss_begin();
    @(negedge clk); ss_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic ss_end();
    wait_clk(HP); ss_n = 1'b1;
    wait_clk(HP);
  endtask

  task automatic xfer(input int nbits, input logic [15:0] mo, output logic [15:0] mi);
    mi = '0;
    for (int b = nbits - 1; b >= 0; b--) begin
      if (!cpha) begin
        mosi = mo[b];
        wait_clk(HP); mi[b] = miso;
        sclk = ~cpol;
        wait_clk(HP);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = mo[b];
        wait_clk(HP); mi[b] = miso;
        sclk = cpol;
        wait_clk(HP);
      end
    end
    wait_clk(HP);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, tx, lo, hi;
    logic [15:0] mi, mo, w;
    logic [1:0] m;
    void'($urandom(32'd4242));
    wait_clk(5); rst = 1'b0; wait_clk(3);

    // R1 reset state
    rd(1'b0, 2'd3, d); chk("R1 stat0", d, stat(0, 1, 0, 0));
    rd(1'b1, 2'd3, d); chk("R1 stat1", d, stat(0, 1, 0, 0));
    chk("R1 irq", irq, 0);
    chk("R1 miso", miso, 0);

    // R2 basic unchained exchange, mode 0
    set_mode(2'd0, 0, 0, 0, 1);
    wr(1'b0, 2'd0, 8'hA5);
    wait_clk(2);
    rd(1'b0, 2'd3, d); chk("R2 loaded stat", d, stat(0, 1, 0, 0));
    ss_begin(); xfer(8, 16'h003C, mi); ss_end();
    chk("R2 miso word", mi[7:0], 8'hA5);
    rd(1'b0, 2'd3, d); chk("R2 done stat", d, stat(1, 1, 0, 0));
    rd(1'b0, 2'd1, d); chk("R2 rx", d, 8'h3C);

    // R3 random exchanges in all modes
    for (int i = 0; i < 12; i++) begin
      m = 2'(i % 4);
      tx = 8'($urandom); lo = 8'($urandom);
      set_mode(m, 0, 0, 0, 1);
      wr(1'b0, 2'd0, tx); wait_clk(2);
      ss_begin(); xfer(8, {8'h0, lo}, mi); ss_end();
      chk($sformatf("R3 miso mode %0d", m), mi[7:0], tx);
      rd(1'b0, 2'd1, d); chk($sformatf("R3 rx mode %0d", m), d, lo);
      rd(1'b0, 2'd3, d);
    end

    // R4 chained 16-bit, R5 slice 1 enable left clear
    wr(1'b1, 2'd2, 8'h00);
    for (int i = 0; i < 8; i++) begin
      m = 2'($urandom % 4);
      hi = 8'($urandom); lo = 8'($urandom); mo = 16'($urandom);
      set_mode(m, 1, 0, 0, 1);
      wr(1'b1, 2'd0, hi); wr(1'b0, 2'd0, lo); wait_clk(2);
      ss_begin(); xfer(16, mo, mi); ss_end();
      chk($sformatf("R4 miso mode %0d", m), mi, {hi, lo});
      rd(1'b1, 2'd1, d); w[15:8] = d;
      rd(1'b0, 2'd1, d); w[7:0] = d;
      chk("R4 R5 rx word", w, mo);
      rd(1'b0, 2'd3, d);
    end

    // R6 upper-first write ordering
    set_mode(2'd0, 1, 0, 0, 1);
    rd(1'b1, 2'd3, d);
    wr(1'b1, 2'd0, 8'h11); wait_clk(3);
    rd(1'b1, 2'd3, d); chk("R6 upper txe after upper write", d, stat(0, 0, 0, 0));
    wr(1'b0, 2'd0, 8'h22); wait_clk(3);
    rd(1'b1, 2'd3, d); chk("R6 upper txe after lower write", d, stat(0, 1, 0, 0));
    ss_begin(); xfer(16, 16'h0000, mi); ss_end();
    chk("R6 chained word", mi, 16'h1122);
    rd(1'b1, 2'd1, d); rd(1'b0, 2'd1, d); rd(1'b0, 2'd3, d); rd(1'b1, 2'd3, d);

    // R7 / R9 write held during phase-0 transfer
    set_mode(2'd0, 0, 0, 0, 1);
    wr(1'b0, 2'd0, 8'h81); wait_clk(2);
    ss_begin();
    wr(1'b0, 2'd0, 8'h42); wait_clk(2);
    rd(1'b0, 2'd3, d); chk("R7 R9 held while busy", d, stat(0, 0, 0, 1));
    xfer(8, 16'h0, mi); ss_end();
    chk("R7 old byte sent", mi[7:0], 8'h81);
    rd(1'b0, 2'd3, d); chk("R7 loaded at boundary", d, stat(1, 1, 0, 0));
    rd(1'b0, 2'd1, d);
    ss_begin(); xfer(8, 16'h0, mi); ss_end();
    chk("R7 held byte sent next", mi[7:0], 8'h42);
    rd(1'b0, 2'd1, d); rd(1'b0, 2'd3, d);
    // phase-1: select low alone is not in progress
    set_mode(2'd2, 0, 0, 0, 1);
    ss_begin();
    wr(1'b0, 2'd0, 8'h5A); wait_clk(2);
    rd(1'b0, 2'd3, d); chk("R7 phase1 loads at once", d, stat(0, 1, 0, 0));
    xfer(8, 16'h0, mi); ss_end();
    chk("R7 phase1 byte", mi[7:0], 8'h5A);
    rd(1'b0, 2'd1, d); rd(1'b0, 2'd3, d);

    // R8 select held low over two words, both phases
    for (int k = 0; k < 2; k++) begin
      m = (k == 0) ? 2'd0 : 2'd3;
      set_mode(m, 0, 0, 0, 1);
      wr(1'b0, 2'd0, 8'hC3); wait_clk(2);
      ss_begin();
      xfer(8, 16'h0096, mi);
      chk($sformatf("R8 word1 miso mode %0d", m), mi[7:0], 8'hC3);
      rd(1'b0, 2'd1, d); chk("R8 word1 rx", d, 8'h96);
      wr(1'b0, 2'd0, 8'h3C); wait_clk(2);
      xfer(8, 16'h0069, mi);
      chk($sformatf("R8 word2 miso mode %0d", m), mi[7:0], 8'h3C);
      rd(1'b0, 2'd1, d); chk("R8 word2 rx", d, 8'h69);
      ss_end();
      rd(1'b0, 2'd3, d);
    end

    // R10 overrun, R9 status clear
    set_mode(2'd1, 0, 0, 0, 1);
    ss_begin(); xfer(8, 16'h0011, mi); ss_end();
    ss_begin(); xfer(8, 16'h0077, mi); ss_end();
    rd(1'b0, 2'd3, d); chk("R10 overrun stat", d, stat(1, 1, 1, 0));
    rd(1'b0, 2'd1, d); chk("R10 rx overwritten", d, 8'h77);
    rd(1'b0, 2'd3, d); chk("R9 flags cleared by read", d, stat(0, 1, 0, 0));

    // R11 interrupts
    set_mode(2'd0, 0, 1, 0, 1);
    wait_clk(3); chk("R11 irq idle", irq[0], 0);
    ss_begin(); xfer(8, 16'h0055, mi); ss_end();
    chk("R11 irq on done", irq[0], 1);
    rd(1'b0, 2'd3, d); wait_clk(2);
    chk("R11 irq cleared", irq[0], 0);
    rd(1'b0, 2'd1, d);
    set_mode(2'd0, 0, 1, 1, 1);
    wait_clk(3); chk("R11 irq txe source", irq[0], 1);
    ss_begin();
    wr(1'b0, 2'd0, 8'hEE); wait_clk(3);
    chk("R11 irq txe low", irq[0], 0);
    xfer(8, 16'h0, mi); ss_end();
    chk("R11 irq txe back", irq[0], 1);
    rd(1'b0, 2'd1, d); rd(1'b0, 2'd3, d);

    // R12 abort on select rise
    set_mode(2'd0, 0, 0, 0, 1);
    ss_begin(); xfer(3, 16'h0005, mi); ss_end();
    rd(1'b0, 2'd3, d); chk("R12 no done after abort", d, stat(0, 1, 0, 0));
    ss_begin(); xfer(8, 16'h00B7, mi); ss_end();
    rd(1'b0, 2'd1, d); chk("R12 fresh word rx", d, 8'hB7);
    rd(1'b0, 2'd3, d);

    // R5 disabled block ignores clock; slice 1 enable has no effect
    wr(1'b1, 2'd2, 8'h01);
    set_mode(2'd0, 0, 0, 0, 0);
    ss_begin(); xfer(8, 16'h00F0, mi); ss_end();
    rd(1'b0, 2'd3, d); chk("R5 disabled stat", d, stat(0, 1, 0, 0));
    rd(1'b0, 2'd1, d); chk("R5 disabled rx", d, 8'hB7);

    summary();
    $finish;
  end

endmodule